// File: doc/BRIEF.md
# Four-Channel Flow-Control Character Bank with Broadcast Writes

This block holds the software flow-control characters of four serial channels. Each channel has two 8-bit registers: a resume character ("Xon") and a pause character ("Xoff"). Software writes a register over a simple write bus by giving a channel index, a register select and a data byte. The registers drive the transmit logic of each channel directly.

Three commands, accepted only from channel 0's command port, act on all four channels together. Two of them arm a one-shot broadcast. Once a broadcast is armed, the next write to channel 0's register of the matching type lands in all four channels' registers of that type. The block then goes back to per-channel writes. Any other bus traffic while the broadcast is armed is handled as normal per-channel writes and leaves the broadcast armed. The third command loads the default resume character 0x11 into all four resume registers in one cycle.

Top module: `xonxoff_gang_bank`

## Requirements
- R1: Reset is active low and asynchronous. It clears all eight registers to 0x00 and disarms both broadcast modes, so the first write after reset updates only the addressed channel.
- R2: A write with `wrSel`=0 targets a resume register and one with `wrSel`=1 targets a pause register. In per-channel mode, a write updates only the register of that type in channel `wrChan`. The new value is visible on the outputs one clock after the write. With no write and no load command, no register changes.
- R3: Command code 5'b10010 from channel 0 arms the resume broadcast. The next resume write to channel 0 then updates all four resume registers with its data.
- R4: Command code 5'b10011 from channel 0 arms the pause broadcast. The next pause write to channel 0 then updates all four pause registers with its data.
- R5: A broadcast is one-shot. The write that triggers it clears that type's armed state, and later writes are per-channel again.
- R6: While a broadcast is armed, writes to channels 1 to 3 and writes of the other register type act as per-channel writes and leave the broadcast armed.
- R7: Codes 5'b10010, 5'b10011 and 5'b10100 issued with `cmdChan` other than 0 have no effect.
- R8: Command code 5'b10100 from channel 0 sets all four resume registers to 0x11 on the next clock. It leaves the pause registers and both armed states unchanged.
- R9: The two armed states are independent. Arming one does not arm the other, and a write of one type neither triggers nor clears the other type's broadcast.
- R10: When a load command and a resume write occur in the same cycle, the load wins for all resume registers. A pause write in that same cycle still completes.
- R11: When an arm command and a write of the same type to channel 0 occur in the same cycle, the write follows the mode that was in force before that cycle. The broadcast is armed afterwards.
- R12: Any command code other than 5'b10010, 5'b10011 and 5'b10100 leaves all registers and armed states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrChan | input | 2 | Channel index of the write |
| wrSel | input | 1 | 0 selects the resume register, 1 selects the pause register |
| wrData | input | 8 | Write data |
| cmdValid | input | 1 | Command strobe |
| cmdChan | input | 2 | Channel whose command port issued the command |
| cmdCode | input | 5 | Command code |
| xonChars | output | 32 | Resume characters, channel n in bits [8n+7:8n] |
| xoffChars | output | 32 | Pause characters, channel n in bits [8n+7:8n] |

## Verification
Two pairs of functions can fall in the same clock.

- A default load can coincide with a register write. The bench issues the load command in the same vector as a resume write to channel 2, and again together with a pause write to channel 1. It expects all resume registers at 0x11 in both cases, and the pause write applied in the second.
- An arm command can coincide with the write that would trigger it. The bench sends the arm command together with a channel 0 resume write, both with the broadcast disarmed and with it already armed. It expects a per-channel write in the first case and a broadcast in the second. In both cases it then checks that the following channel 0 write is broadcast.

// File: rtl/xog_pkg.sv
package xog_pkg;

  localparam int CMD_W = 5;

  localparam logic [CMD_W-1:0] CMD_ARM_XON  = 5'b10010;
  localparam logic [CMD_W-1:0] CMD_ARM_XOFF = 5'b10011;
  localparam logic [CMD_W-1:0] CMD_LOAD_XON = 5'b10100;

  // Register type index used by the control generate loop
  localparam int TYPE_XON  = 0;
  localparam int TYPE_XOFF = 1;
  localparam int NUM_TYPES = 2;

  // Strobes from control to the register datapath
  typedef struct packed {
    logic indivXon;   // per-channel resume write
    logic indivXoff;  // per-channel pause write
    logic gangXon;    // broadcast resume write
    logic gangXoff;   // broadcast pause write
    logic loadXon;    // load default resume character everywhere
  } strobe_t;

endpackage

// File: rtl/xog_ctrl.sv
module xog_ctrl
  import xog_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CH_W-1:0]  wrChan,
  input  logic             wrSel,
  input  logic             cmdValid,
  input  logic [CH_W-1:0]  cmdChan,
  input  logic [CMD_W-1:0] cmdCode,
  output strobe_t          strobes
);

  logic wrAtChanA;
  logic cmdOnChanA;
  logic [NUM_TYPES-1:0] typeWr;
  logic [NUM_TYPES-1:0] armReq;
  logic [NUM_TYPES-1:0] trigger;
  logic [NUM_TYPES-1:0] armFlag;

  assign wrAtChanA  = (wrChan == '0);
  assign cmdOnChanA = cmdValid && (cmdChan == '0);

  assign typeWr[TYPE_XON]  = wrEn && !wrSel;
  assign typeWr[TYPE_XOFF] = wrEn && wrSel;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    localparam logic [CMD_W-1:0] ARM_CODE = (t == TYPE_XON) ? CMD_ARM_XON : CMD_ARM_XOFF;

    assign armReq[t]  = cmdOnChanA && (cmdCode == ARM_CODE);
    // The trigger uses the state armed before this cycle
    assign trigger[t] = typeWr[t] && wrAtChanA && armFlag[t];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armFlag[t] <= 1'b0;
      end else if (armReq[t]) begin
        armFlag[t] <= 1'b1;
      end else if (trigger[t]) begin
        armFlag[t] <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.gangXon   = trigger[TYPE_XON];
    strobes.gangXoff  = trigger[TYPE_XOFF];
    strobes.indivXon  = typeWr[TYPE_XON]  && !trigger[TYPE_XON];
    strobes.indivXoff = typeWr[TYPE_XOFF] && !trigger[TYPE_XOFF];
    strobes.loadXon   = cmdOnChanA && (cmdCode == CMD_LOAD_XON);
  end

endmodule

// File: rtl/xog_regs.sv
module xog_regs
  import xog_pkg::*;
#(
  parameter int                NUM_CH      = 4,
  parameter int                DATA_W      = 8,
  parameter int                CH_W        = 2,
  parameter logic [DATA_W-1:0] XON_DEFAULT = 8'h11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  logic [CH_W-1:0]          wrChan,
  input  logic [DATA_W-1:0]        wrData,
  output logic [NUM_CH*DATA_W-1:0] xonFlat,
  output logic [NUM_CH*DATA_W-1:0] xoffFlat
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic              selHere;
    logic [DATA_W-1:0] xonReg;
    logic [DATA_W-1:0] xoffReg;

    assign selHere = (wrChan == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        xonReg  <= '0;
        xoffReg <= '0;
      end else begin
        // The default load takes priority over any resume write
        if (strobes.loadXon) begin
          xonReg <= XON_DEFAULT;
        end else if (strobes.gangXon || (strobes.indivXon && selHere)) begin
          xonReg <= wrData;
        end
        if (strobes.gangXoff || (strobes.indivXoff && selHere)) begin
          xoffReg <= wrData;
        end
      end
    end

    assign xonFlat[c*DATA_W +: DATA_W]  = xonReg;
    assign xoffFlat[c*DATA_W +: DATA_W] = xoffReg;
  end

endmodule

// File: rtl/xonxoff_gang_bank.sv
module xonxoff_gang_bank
  import xog_pkg::*;
#(
  parameter int                NUM_CH      = 4,
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] XON_DEFAULT = 8'h11,
  localparam int               CH_W        = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [CH_W-1:0]          wrChan,
  input  logic                     wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     cmdValid,
  input  logic [CH_W-1:0]          cmdChan,
  input  logic [CMD_W-1:0]         cmdCode,
  output logic [NUM_CH*DATA_W-1:0] xonChars,
  output logic [NUM_CH*DATA_W-1:0] xoffChars
);

  strobe_t strobes;

  xog_ctrl #(
    .CH_W(CH_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrChan  (wrChan),
    .wrSel   (wrSel),
    .cmdValid(cmdValid),
    .cmdChan (cmdChan),
    .cmdCode (cmdCode),
    .strobes (strobes)
  );

  xog_regs #(
    .NUM_CH     (NUM_CH),
    .DATA_W     (DATA_W),
    .CH_W       (CH_W),
    .XON_DEFAULT(XON_DEFAULT)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrChan  (wrChan),
    .wrData  (wrData),
    .xonFlat (xonChars),
    .xoffFlat(xoffChars)
  );

endmodule

// File: rtl/xog_checker.sv
module xog_checker
  import xog_pkg::*;
#(
  parameter int                NUM_CH      = 4,
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] XON_DEFAULT = 8'h11,
  parameter int                CH_W        = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [CH_W-1:0]          wrChan,
  input logic                     wrSel,
  input logic [DATA_W-1:0]        wrData,
  input logic                     cmdValid,
  input logic [CH_W-1:0]          cmdChan,
  input logic [CMD_W-1:0]         cmdCode,
  input logic [NUM_CH*DATA_W-1:0] xonChars,
  input logic [NUM_CH*DATA_W-1:0] xoffChars
);

  logic loadCmd;
  assign loadCmd = cmdValid && (cmdChan == '0) && (cmdCode == CMD_LOAD_XON);

  // R8: the default load reaches every resume register
  assert_load_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadCmd |=> (xonChars == {NUM_CH{XON_DEFAULT}}));

  // R8: the default load leaves the pause registers alone
  assert_load_keeps_xoff_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadCmd && !(wrEn && wrSel)) |=> $stable(xoffChars));

  // R2: with no write and no load, nothing changes
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !loadCmd) |=> ($stable(xonChars) && $stable(xoffChars)));

  // R2: the addressed pause register always takes the written data
  assert_xoff_written_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (xoffChars[$past(wrChan)*DATA_W +: DATA_W] == $past(wrData)));

  // R2: the addressed resume register takes the data unless a load wins (R10)
  assert_xon_written_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && !loadCmd) |=> (xonChars[$past(wrChan)*DATA_W +: DATA_W] == $past(wrData)));

endmodule

bind xonxoff_gang_bank xog_checker #(
  .NUM_CH     (NUM_CH),
  .DATA_W     (DATA_W),
  .XON_DEFAULT(XON_DEFAULT),
  .CH_W       (CH_W)
) i_xog_checker (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrChan   (wrChan),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .cmdValid (cmdValid),
  .cmdChan  (cmdChan),
  .cmdCode  (cmdCode),
  .xonChars (xonChars),
  .xoffChars(xoffChars)
);

// File: tb/test_xonxoff_gang_bank.sv
module test_xonxoff_gang_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VECS   = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrChan = '0;
  logic        wrSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdChan = '0;
  logic [4:0]  cmdCode = '0;
  logic [31:0] xonChars;
  logic [31:0] xoffChars;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xonxoff_gang_bank i_xonxoff_gang_bank (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrChan   (wrChan),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .cmdValid (cmdValid),
    .cmdChan  (cmdChan),
    .cmdCode  (cmdCode),
    .xonChars (xonChars),
    .xoffChars(xoffChars)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        wrEn;
    logic [1:0]  wrChan;
    logic        wrSel;
    logic [7:0]  wrData;
    logic        cmdValid;
    logic [1:0]  cmdChan;
    logic [4:0]  cmdCode;
    logic [31:0] expXon;
    logic [31:0] expXoff;
  } vec_t;

  // Expected register contents after each step; channel 3 is the top byte
  localparam vec_t VECS [NUM_VECS] = '{
    '{8'd2,  1'b1, 2'd1, 1'b0, 8'hA1, 1'b0, 2'd0, 5'b00000, 32'h0000A100, 32'h00000000}, // R2
    '{8'd2,  1'b1, 2'd2, 1'b1, 8'hB2, 1'b0, 2'd0, 5'b00000, 32'h0000A100, 32'h00B20000}, // R2
    '{8'd7,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd2, 5'b10010, 32'h0000A100, 32'h00B20000}, // R7
    '{8'd7,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd1, 5'b10100, 32'h0000A100, 32'h00B20000}, // R7
    '{8'd7,  1'b1, 2'd0, 1'b0, 8'h0F, 1'b0, 2'd0, 5'b00000, 32'h0000A10F, 32'h00B20000}, // R7
    '{8'd12, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 5'b00110, 32'h0000A10F, 32'h00B20000}, // R12
    '{8'd3,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 5'b10010, 32'h0000A10F, 32'h00B20000}, // R3
    '{8'd6,  1'b1, 2'd3, 1'b0, 8'hC3, 1'b0, 2'd0, 5'b00000, 32'hC300A10F, 32'h00B20000}, // R6
    '{8'd6,  1'b1, 2'd0, 1'b1, 8'h44, 1'b0, 2'd0, 5'b00000, 32'hC300A10F, 32'h00B20044}, // R6
    '{8'd3,  1'b1, 2'd0, 1'b0, 8'h5A, 1'b0, 2'd0, 5'b00000, 32'h5A5A5A5A, 32'h00B20044}, // R3
    '{8'd5,  1'b1, 2'd0, 1'b0, 8'h66, 1'b0, 2'd0, 5'b00000, 32'h5A5A5A66, 32'h00B20044}, // R5
    '{8'd4,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 5'b10011, 32'h5A5A5A66, 32'h00B20044}, // R4
    '{8'd9,  1'b1, 2'd0, 1'b0, 8'h77, 1'b0, 2'd0, 5'b00000, 32'h5A5A5A77, 32'h00B20044}, // R9
    '{8'd4,  1'b1, 2'd0, 1'b1, 8'h99, 1'b0, 2'd0, 5'b00000, 32'h5A5A5A77, 32'h99999999}, // R4
    '{8'd5,  1'b1, 2'd2, 1'b1, 8'h12, 1'b0, 2'd0, 5'b00000, 32'h5A5A5A77, 32'h99129999}, // R5
    '{8'd8,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 5'b10100, 32'h11111111, 32'h99129999}, // R8
    '{8'd10, 1'b1, 2'd2, 1'b0, 8'h33, 1'b1, 2'd0, 5'b10100, 32'h11111111, 32'h99129999}, // R10
    '{8'd10, 1'b1, 2'd1, 1'b1, 8'h21, 1'b1, 2'd0, 5'b10100, 32'h11111111, 32'h99122199}, // R10
    '{8'd11, 1'b1, 2'd0, 1'b0, 8'h40, 1'b1, 2'd0, 5'b10010, 32'h11111140, 32'h99122199}, // R11
    '{8'd11, 1'b1, 2'd0, 1'b0, 8'h41, 1'b0, 2'd0, 5'b00000, 32'h41414141, 32'h99122199}, // R11
    '{8'd3,  1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 2'd0, 5'b10010, 32'h41414141, 32'h99122199}, // R3
    '{8'd11, 1'b1, 2'd0, 1'b0, 8'h52, 1'b1, 2'd0, 5'b10010, 32'h52525252, 32'h99122199}, // R11
    '{8'd11, 1'b1, 2'd0, 1'b0, 8'h53, 1'b0, 2'd0, 5'b00000, 32'h53535353, 32'h99122199}, // R11
    '{8'd5,  1'b1, 2'd0, 1'b0, 8'h54, 1'b0, 2'd0, 5'b00000, 32'h53535354, 32'h99122199}  // R5
  };

  task automatic checkOut(input string req, input logic [31:0] expXon, input logic [31:0] expXoff);
    checks++;
    if (xonChars !== expXon || xoffChars !== expXoff) begin
      failures++;
      $display("FAIL %s: xon=%h xoff=%h expected xon=%h xoff=%h",
               req, xonChars, xoffChars, expXon, expXoff);
    end
  endtask

  task automatic idleInputs();
    wrEn = 1'b0; wrChan = '0; wrSel = 1'b0; wrData = '0;
    cmdValid = 1'b0; cmdChan = '0; cmdCode = '0;
  endtask

  task automatic issueCmd(input logic [4:0] code);
    cmdValid = 1'b1; cmdChan = 2'd0; cmdCode = code;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic issueWrite(input logic [1:0] ch, input logic sel, input logic [7:0] data);
    wrEn = 1'b1; wrChan = ch; wrSel = sel; wrData = data;
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    checkOut("R1", 32'h0, 32'h0);   // reset state
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NUM_VECS; i++) begin
      wrEn     = VECS[i].wrEn;
      wrChan   = VECS[i].wrChan;
      wrSel    = VECS[i].wrSel;
      wrData   = VECS[i].wrData;
      cmdValid = VECS[i].cmdValid;
      cmdChan  = VECS[i].cmdChan;
      cmdCode  = VECS[i].cmdCode;
      @(negedge clk);
      checkOut($sformatf("R%0d step %0d", VECS[i].req, i), VECS[i].expXon, VECS[i].expXoff);
    end
    idleInputs();

    // R1: reset in the middle of armed broadcasts clears registers and armed states
    issueCmd(5'b10010);
    issueCmd(5'b10011);
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 mid-run reset", 32'h0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    issueWrite(2'd0, 1'b0, 8'h01);
    checkOut("R1 resume disarmed", 32'h00000001, 32'h0);
    issueWrite(2'd0, 1'b1, 8'h02);
    checkOut("R1 pause disarmed", 32'h00000001, 32'h00000002);

    // R9: arming the pause broadcast alone leaves resume writes per-channel
    issueCmd(5'b10011);
    issueWrite(2'd0, 1'b0, 8'h03);
    checkOut("R9 resume not armed", 32'h00000003, 32'h00000002);
    issueWrite(2'd0, 1'b1, 8'h7E);
    checkOut("R9 pause still armed", 32'h00000003, 32'h7E7E7E7E);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule